// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a 16-bit logical address into a 16-bit physical address using a small segment table held inside the block. The top bits of the logical address select a segment and the low bits give an offset into it. The block makes two legality checks. First the segment number must be below the programmed segment count. Then the offset must be below the limit stored for that segment. If both checks pass, the block adds the offset to the segment's base to form the physical address.

Software or a control block loads table entries through a synchronous write port, one entry per cycle, and loads the segment count through a separate strobe. A request is presented as a valid pulse with an address. The result appears on registered outputs one cycle later, together with a done pulse and a fault code. The fault code tells apart a bad segment number, an offset beyond the limit, and a sum that does not fit in the physical address width.

Top module: `seg_xlate`

## Requirements
- R1: The logical address is split so that bits [15:12] are the segment number and bits [11:0] are the offset.
- R2: When `tbl_we_i` is high at a rising edge, the entry at index `tbl_idx_i` takes `tbl_base_i` and `tbl_limit_i`. A write whose index is 16 or more leaves every entry unchanged.
- R3: A request whose segment number is greater than or equal to the segment count gives fault code 1.
- R4: A request with a legal segment whose offset is greater than or equal to that entry's limit gives fault code 2. A limit of 0 makes every offset fault.
- R5: A request that passes both checks, but whose base plus offset exceeds 0xFFFF, gives fault code 3.
- R6: A request that passes all checks gives code 0, a low fault flag, and a physical address equal to base plus offset. For example, base 0x2020 with offset 0x2F0 gives 0x2310.
- R7: `done_o` is high for exactly one cycle, in the cycle after each cycle in which `req_valid_i` is high. In cycles without done, all result outputs are 0.
- R8: When several faults apply, code 1 wins over code 2, and code 2 wins over code 3.
- R9: A synchronous active-high reset clears the segment count to 0 and all outputs to 0, so every request after reset faults with code 1 until the count is loaded.
- R10: `seg_cnt_we_i` loads `seg_cnt_i` (0 to 16) into the segment count at the rising edge. On a fault, `fault_o` is high and `phys_o` is 0; `fault_o` is high exactly when the code is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | Translation request strobe |
| req_addr_i | input | 16 | Logical address: segment and offset |
| tbl_we_i | input | 1 | Table entry write enable |
| tbl_idx_i | input | 5 | Entry index; values of 16 and above are ignored |
| tbl_base_i | input | 16 | Base physical address for the entry |
| tbl_limit_i | input | 12 | Segment length for the entry |
| seg_cnt_we_i | input | 1 | Load strobe for the segment count |
| seg_cnt_i | input | 5 | New segment count |
| done_o | output | 1 | One-cycle result strobe |
| phys_o | output | 16 | Physical address; 0 on fault |
| fault_o | output | 1 | Fault flag |
| fault_code_o | output | 2 | 0 ok, 1 segment, 2 limit, 3 overflow |

## Verification
A corrupted table entry or segment count shows up on the very next done pulse after a request to that segment. It appears either as a wrong physical sum or as a fault code of the wrong kind. A wrong count shows up first at the boundary segments, one below and at the count. A wrong limit shows up at offsets equal to the limit and one below it. A lost or doubled done pulse is seen on the cycle after the request. For this reason the bench compares every output on every cycle against a behavioural model, including idle cycles, so that any stray pulse is also caught.

// File: rtl/seg_pkg.sv
package seg_pkg;
  typedef enum logic [1:0] {
    FC_OK  = 2'd0,
    FC_SEG = 2'd1,
    FC_LIM = 2'd2,
    FC_OVF = 2'd3
  } fault_e;
endpackage

// File: rtl/seg_table.sv
// Segment entry storage: synchronous write, asynchronous read (distributed RAM).
module seg_table #(
  parameter int SEG_W  = 4,
  parameter int OFF_W  = 12,
  parameter int PHYS_W = 16
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SEG_W:0]    wr_idx,
  input  logic [PHYS_W-1:0] wr_base,
  input  logic [OFF_W-1:0]  wr_lim,
  input  logic [SEG_W-1:0]  rd_idx,
  output logic [PHYS_W-1:0] rd_base,
  output logic [OFF_W-1:0]  rd_lim
);
  localparam int DEPTH = 1 << SEG_W;

  logic [PHYS_W-1:0] base_mem [DEPTH];
  logic [OFF_W-1:0]  lim_mem  [DEPTH];
  logic              idx_ok;

  // R2: an index with the extra high bit set is outside the table and is dropped
  assign idx_ok = (wr_idx[SEG_W] == 1'b0);

  always_ff @(posedge clk) begin
    if (wr_en && idx_ok) begin
      base_mem[wr_idx[SEG_W-1:0]] <= wr_base;
      lim_mem[wr_idx[SEG_W-1:0]]  <= wr_lim;
    end
  end

  assign rd_base = base_mem[rd_idx];
  assign rd_lim  = lim_mem[rd_idx];
endmodule

// File: rtl/seg_check.sv
// Combinational legality checks and base+offset adder.
module seg_check
  import seg_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int OFF_W  = 12,
  parameter int PHYS_W = 16
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic [SEG_W:0]    seg_cnt,
  input  logic [PHYS_W-1:0] base,
  input  logic [OFF_W-1:0]  lim,
  output fault_e            code,
  output logic [PHYS_W-1:0] sum
);
  localparam int PAD_W = PHYS_W + 1 - OFF_W;

  logic [PHYS_W:0] wide_sum;
  logic            seg_bad, lim_bad, ovf_bad;

  assign wide_sum = {1'b0, base} + {{PAD_W{1'b0}}, off};
  assign sum      = wide_sum[PHYS_W-1:0];

  assign seg_bad = ({1'b0, seg} >= seg_cnt);
  assign lim_bad = (off >= lim);
  assign ovf_bad = wide_sum[PHYS_W];

  // R8: segment check first, limit check second, overflow last
  always_comb begin
    if (seg_bad)      code = FC_SEG;
    else if (lim_bad) code = FC_LIM;
    else if (ovf_bad) code = FC_OVF;
    else              code = FC_OK;
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 4,
  parameter int PHYS_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              tbl_we_i,
  input  logic [SEG_W:0]    tbl_idx_i,
  input  logic [PHYS_W-1:0] tbl_base_i,
  input  logic [ADDR_W-SEG_W-1:0] tbl_limit_i,
  input  logic              seg_cnt_we_i,
  input  logic [SEG_W:0]    seg_cnt_i,
  output logic              done_o,
  output logic [PHYS_W-1:0] phys_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o
);
  localparam int OFF_W = ADDR_W - SEG_W;

  logic [SEG_W-1:0]  req_seg;
  logic [OFF_W-1:0]  req_off;
  logic [SEG_W:0]    cnt_q;
  logic [PHYS_W-1:0] ent_base;
  logic [OFF_W-1:0]  ent_lim;
  logic [PHYS_W-1:0] sum;
  fault_e            code;

  // R1: segment in the upper bits, offset below
  assign req_seg = req_addr_i[ADDR_W-1:OFF_W];
  assign req_off = req_addr_i[OFF_W-1:0];

  seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PHYS_W(PHYS_W)) u_table (
    .clk     (clk),
    .wr_en   (tbl_we_i),
    .wr_idx  (tbl_idx_i),
    .wr_base (tbl_base_i),
    .wr_lim  (tbl_limit_i),
    .rd_idx  (req_seg),
    .rd_base (ent_base),
    .rd_lim  (ent_lim)
  );

  seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PHYS_W(PHYS_W)) u_check (
    .seg     (req_seg),
    .off     (req_off),
    .seg_cnt (cnt_q),
    .base    (ent_base),
    .lim     (ent_lim),
    .code    (code),
    .sum     (sum)
  );

  // R9, R10: segment count register
  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (seg_cnt_we_i) cnt_q <= seg_cnt_i;
  end

  // R7: one-cycle registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      done_o       <= 1'b0;
      phys_o       <= '0;
      fault_o      <= 1'b0;
      fault_code_o <= 2'd0;
    end else begin
      done_o <= req_valid_i;
      if (req_valid_i) begin
        fault_code_o <= code;
        fault_o      <= (code != FC_OK);
        phys_o       <= (code == FC_OK) ? sum : '0;
      end else begin
        fault_code_o <= 2'd0;
        fault_o      <= 1'b0;
        phys_o       <= '0;
      end
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 4,
  parameter int PHYS_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              done_o,
  input logic [PHYS_W-1:0] phys_o,
  input logic              fault_o,
  input logic [1:0]        fault_code_o,
  input logic [SEG_W:0]    cnt_q
);
  // R7
  a_r7_done_after_req: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> done_o);

  // R7
  a_r7_done_needs_req: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(req_valid_i));

  // R3
  a_r3_seg_fault: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && ({1'b0, req_addr_i[ADDR_W-1:ADDR_W-SEG_W]} >= cnt_q))
      |=> (fault_code_o == 2'd1));

  // R10
  a_r10_zero_on_fault: assert property (@(posedge clk) disable iff (rst)
    fault_o |-> (phys_o == '0));

  // R10
  a_r10_flag_matches_code: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (fault_o == (fault_code_o != 2'd0)));

  // R9
  a_r9_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (cnt_q == '0 && !done_o && !fault_o));
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .PHYS_W(PHYS_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid_i  (req_valid_i),
  .req_addr_i   (req_addr_i),
  .done_o       (done_o),
  .phys_o       (phys_o),
  .fault_o      (fault_o),
  .fault_code_o (fault_code_o),
  .cnt_q        (cnt_q)
);

// File: tb/tb_seg_xlate.sv
`timescale 1ns/1ps
module tb_seg_xlate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [4:0]  tbl_idx_i = '0;
  logic [15:0] tbl_base_i = '0;
  logic [11:0] tbl_limit_i = '0;
  logic        seg_cnt_we_i = 1'b0;
  logic [4:0]  seg_cnt_i = '0;
  logic        done_o, fault_o;
  logic [15:0] phys_o;
  logic [1:0]  fault_code_o;

  always #10 clk = ~clk; // 50 MHz

  seg_xlate dut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .tbl_we_i(tbl_we_i), .tbl_idx_i(tbl_idx_i), .tbl_base_i(tbl_base_i),
    .tbl_limit_i(tbl_limit_i), .seg_cnt_we_i(seg_cnt_we_i), .seg_cnt_i(seg_cnt_i),
    .done_o(done_o), .phys_o(phys_o), .fault_o(fault_o), .fault_code_o(fault_code_o)
  );

  // behavioural reference state
  int    m_base [16];
  int    m_lim  [16];
  int    m_cnt;
  int    e_done, e_phys, e_fault, e_code;
  string stim_tag = "R9";
  string e_tag = "R9";
  int    n_cmp = 0, n_bad = 0;
  int    cycles = 0;
  bit    finished = 0;

  always @(posedge clk) begin
    cycles++;
    e_tag = stim_tag;
    if (rst) begin
      m_cnt = 0; e_done = 0; e_phys = 0; e_fault = 0; e_code = 0;
    end else begin
      e_done = req_valid_i; e_phys = 0; e_fault = 0; e_code = 0;
      if (req_valid_i) begin
        int s, o, total;
        s = req_addr_i / 4096;
        o = req_addr_i % 4096;
        total = m_base[s] + o;
        if (s >= m_cnt)          e_code = 1;
        else if (o >= m_lim[s])  e_code = 2;
        else if (total > 65535)  e_code = 3;
        else                     e_phys = total;
        e_fault = (e_code != 0);
      end
      if (tbl_we_i && tbl_idx_i < 16) begin
        m_base[tbl_idx_i] = tbl_base_i;
        m_lim[tbl_idx_i]  = tbl_limit_i;
      end
      if (seg_cnt_we_i) m_cnt = seg_cnt_i;
    end
  end

  always @(negedge clk) begin
    if (cycles > 0 && !finished) begin
      n_cmp++;
      if (done_o !== e_done[0] || phys_o !== e_phys[15:0] ||
          fault_o !== e_fault[0] || fault_code_o !== e_code[1:0]) begin
        n_bad++;
        $display("FAIL %s: got done=%0d phys=%h fault=%0d code=%0d, expected done=%0d phys=%h fault=%0d code=%0d",
                 e_tag, done_o, phys_o, fault_o, fault_code_o,
                 e_done, e_phys[15:0], e_fault, e_code);
      end
    end
  end

  task automatic step(input string tag);
    stim_tag = tag;
    @(negedge clk); #1;
  endtask

  task automatic wr_entry(input int idx, input int base, input int lim);
    tbl_we_i = 1; tbl_idx_i = idx[4:0]; tbl_base_i = base[15:0]; tbl_limit_i = lim[11:0];
    step("R2");
    tbl_we_i = 0;
  endtask

  task automatic set_cnt(input int c);
    seg_cnt_we_i = 1; seg_cnt_i = c[4:0];
    step("R10");
    seg_cnt_we_i = 0;
  endtask

  task automatic xlate(input int seg, input int off, input string tag);
    req_valid_i = 1; req_addr_i = {seg[3:0], off[11:0]};
    stim_tag = tag;
    @(negedge clk); #1;
    req_valid_i = 0;
    step(tag); // result cycle compared here
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    @(negedge clk); #1;
    step("R9"); step("R9");
    rst = 0;
    xlate(2, 5, "R9");           // count 0 after reset -> code 1
    for (int i = 0; i < 16; i++) wr_entry(i, (i * 4096) + 256, 12'h800);
    wr_entry(1, 16'h2020, 12'h79E);
    wr_entry(3, 16'h3000, 0);
    wr_entry(14, 16'hFFF0, 12'h020);
    wr_entry(15, 16'hFF00, 12'hFFF);
    set_cnt(4);
    xlate(5, 0, "R3");
    xlate(4, 0, "R3");           // boundary: seg == count
    xlate(3, 0, "R4");           // limit 0
    xlate(2, 12'h7FF, "R6");
    set_cnt(16);
    xlate(1, 12'h2F0, "R6");     // 0x2310
    xlate(1, 12'h79D, "R4");     // last legal offset
    xlate(1, 12'h79E, "R4");     // offset == limit
    xlate(15, 12'h0FF, "R5");    // 0xFFFF, fits
    xlate(15, 12'h100, "R5");    // overflows
    xlate(14, 12'h020, "R8");    // limit beats overflow
    xlate(2, 12'hABC, "R1");
    xlate(10, 12'h001, "R1");
    set_cnt(2);
    xlate(15, 12'hF00, "R8");    // segment beats overflow
    set_cnt(16);
    wr_entry(17, 0, 0);          // alias of 1, dropped
    wr_entry(31, 0, 0);          // alias of 15, dropped
    xlate(1, 12'h2F0, "R2");
    xlate(15, 12'h0FF, "R2");
    // back-to-back requests, mixed table writes
    for (int k = 0; k < 200; k++) begin
      req_valid_i = (k % 5) != 4;
      req_addr_i = 16'((k * 40503 + 12345) & 16'hFFFF);
      tbl_we_i = (k % 7) == 0;
      tbl_idx_i = 5'((k * 3) % 20);
      tbl_base_i = 16'((k * 977) & 16'hFFFF);
      tbl_limit_i = 12'((k * 211) & 12'hFFF);
      step("R7");
    end
    req_valid_i = 0; tbl_we_i = 0;
    step("R7"); step("R7");
    rst = 1; step("R9");
    rst = 0;
    xlate(1, 0, "R9");
    finish_run();
  end

  initial begin
    wait (cycles > 100000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hang, expected completion");
      finish_run();
    end
  end
endmodule